// File: doc/BRIEF.md
# Serial Control Port with Status Readback

This block is the slave side of a three-wire serial control bus: a data input, a serial clock and an active-low chip select. A host sends 16-bit frames that carry a 7-bit register address and then a 9-bit data word. The block holds a small bank of 9-bit configuration registers whose contents drive the rest of the device through a flat output bus.

A register write takes effect only when chip select is released. It takes effect only if exactly sixteen bits were clocked in. Addresses beyond the bank are accepted as dummy targets and change nothing.

When readback is enabled, any ordinary write frame also returns one 8-bit read-only status byte on the serial output. The byte is shifted out during the second half of the frame. A field in the control register chooses which of eight status inputs is returned.

All three bus lines are synchronized into the system clock domain. Edges are detected there, so the serial clock must be much slower than the system clock.

Top module: `spiCtrlPort`

## Requirements
- R1: After reset every configuration register reads zero on `cfgOut` and `sdo` is low.
- R2: A 16-bit frame is shifted in MSB first, with address bits [15:9] before data bits [8:0]. On the rising edge of chip select the data is written to register `addr`, which appears at `cfgOut[9*addr +: 9]`.
- R3: A frame that holds fewer or more than 16 bits when chip select rises updates no register.
- R4: A frame addressed at 8 or above is accepted but changes no register.
- R5: Register 7 is the control register. Bit 0 enables readback, bit 1 selects the in-write readback method, and bits [4:2] select the status byte. A byte is returned only when bits 0 and 1 are both 1; otherwise `sdo` stays low for the whole frame.
- R6: When readback is on, status byte `k` (`statusIn[8k +: 8]`) is returned MSB first. Bit 7 appears after the 9th rising serial clock edge, and the output advances one bit on each later falling edge. During the high phase of clock periods 9 through 16 the output therefore shows bits 7 down to 0.
- R7: The control register value at the falling edge of chip select decides that frame's readback. A write that changes it affects only later frames.
- R8: `sdo` is low while chip select is high.
- R9: The status byte is captured at the 9th rising serial clock edge. Later changes on `statusIn` do not alter the byte being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on sclk rising edge |
| statusIn | input | 64 | Eight read-only status bytes, byte k at [8k+7:8k] |
| cfgOut | output | 72 | Register bank, register r at [9r+8:9r] |
| sdo | output | 1 | Serial readback data |

## Verification
The assertions assume that chip select is never asserted at the same moment as a serial clock edge. They also assume that every serial clock phase lasts several system clocks, so that each bus edge produces exactly one strobe after synchronization. The stimulus follows both rules. It lowers chip select and waits a full half period before the first clock, holds each serial clock phase for eight system clocks, and changes data only while the serial clock is low. Status inputs change only between frames, except in the one deliberate case where they change after the capture edge.

// File: rtl/spiCtrlPkg.sv
package spiCtrlPkg;
  // Strobes passed from the bus sequencer to the datapath, one system clock wide.
  typedef struct packed {
    logic active;    // chip select asserted (synchronized)
    logic start;     // chip select falling edge
    logic sample;    // serial clock rising edge inside a frame
    logic loadStat;  // rising edge that captures the status byte
    logic shiftOut;  // falling edge that advances the output byte
    logic commit;    // chip select rising edge after a complete frame
  } ctrlStrobeT;
endpackage

// File: rtl/spiCtrlSeq.sv
module spiCtrlSeq
  import spiCtrlPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int STAT_BITS  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdiBit,
  output ctrlStrobeT st
);
  localparam int CW      = $clog2(FRAME_BITS * 2);
  localparam int LOAD_AT = FRAME_BITS - STAT_BITS;

  logic csMeta, csSync, csPrev;
  logic ckMeta, ckSync, ckPrev;
  logic sdMeta, sdSync;
  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta <= 1'b1; csSync <= 1'b1; csPrev <= 1'b1;
      ckMeta <= 1'b0; ckSync <= 1'b0; ckPrev <= 1'b0;
      sdMeta <= 1'b0; sdSync <= 1'b0;
    end else begin
      csMeta <= csN;  csSync <= csMeta; csPrev <= csSync;
      ckMeta <= sclk; ckSync <= ckMeta; ckPrev <= ckSync;
      sdMeta <= sdi;  sdSync <= sdMeta;
    end
  end

  logic csFall, csRise, ckRise, ckFall;
  always_comb begin
    csFall = csPrev & ~csSync;
    csRise = ~csPrev & csSync;
    ckRise = ~csSync & ckSync & ~ckPrev;
    ckFall = ~csSync & ~ckSync & ckPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (csFall)
      bitCnt <= '0;
    else if (ckRise && bitCnt != '1)
      bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    sdiBit      = sdSync;
    st.active   = ~csSync;
    st.start    = csFall;
    st.sample   = ckRise;
    st.loadStat = ckRise && (bitCnt == CW'(LOAD_AT));
    st.shiftOut = ckFall && (bitCnt > CW'(LOAD_AT));
    st.commit   = csRise && (bitCnt == CW'(FRAME_BITS));
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    st.start |=> bitCnt == '0); // R3
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.commit, st.loadStat, st.shiftOut})); // R6
endmodule

// File: rtl/spiCtrlData.sv
module spiCtrlData
  import spiCtrlPkg::*;
#(
  parameter int NREG      = 8,
  parameter int AW        = 7,
  parameter int DW        = 9,
  parameter int SELW      = 3,
  parameter int SB        = 8,
  parameter int CTRL_ADDR = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               st,
  input  logic                     sdiBit,
  input  logic [(SB<<SELW)-1:0]    statusIn,
  output logic [NREG*DW-1:0]       cfgOut,
  output logic                     sdo
);
  localparam int FW = AW + DW;

  logic [FW-1:0]   rxShift;
  logic [AW-1:0]   rxAddr;
  logic [DW-1:0]   rxData;
  logic [DW-1:0]   bank [NREG];
  logic            rbOn;
  logic [SELW-1:0] selReg;
  logic [SB-1:0]   outSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rxShift <= '0;
    else if (st.sample)
      rxShift <= {rxShift[FW-2:0], sdiBit};
  end

  assign rxAddr = rxShift[FW-1:DW];
  assign rxData = rxShift[DW-1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[r] <= '0;
      else if (st.commit && rxAddr == AW'(r))
        bank[r] <= rxData;
    end
    assign cfgOut[r*DW +: DW] = bank[r];
  end

  logic [DW-1:0] ctrlWord;
  assign ctrlWord = bank[CTRL_ADDR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbOn   <= 1'b0;
      selReg <= '0;
    end else if (st.start) begin
      rbOn   <= ctrlWord[0] & ctrlWord[1];
      selReg <= ctrlWord[2 +: SELW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      outSh <= '0;
    else if (st.start)
      outSh <= '0;
    else if (st.loadStat)
      outSh <= rbOn ? statusIn[selReg*SB +: SB] : '0;
    else if (st.shiftOut)
      outSh <= {outSh[SB-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sdo <= 1'b0;
    else
      sdo <= st.active & outSh[SB-1];
  end

  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> !st.active); // R2
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(cfgOut)); // R3
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadStat && !rbOn) |=> outSh == '0); // R5
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (st.active && !st.start) |=> $stable(selReg)); // R7
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !st.active |=> !sdo); // R8
endmodule

// File: rtl/spiCtrlPort.sv
module spiCtrlPort
  import spiCtrlPkg::*;
#(
  parameter int NREG      = 8,
  parameter int AW        = 7,
  parameter int DW        = 9,
  parameter int SELW      = 3,
  parameter int SB        = 8,
  parameter int CTRL_ADDR = NREG - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic [(SB<<SELW)-1:0]  statusIn,
  output logic [NREG*DW-1:0]     cfgOut,
  output logic                   sdo
);
  ctrlStrobeT st;
  logic sdiBit;

  spiCtrlSeq #(.FRAME_BITS(AW + DW), .STAT_BITS(SB)) u_seq (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdiBit(sdiBit), .st(st)
  );

  spiCtrlData #(.NREG(NREG), .AW(AW), .DW(DW), .SELW(SELW), .SB(SB),
                .CTRL_ADDR(CTRL_ADDR)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .sdiBit(sdiBit),
    .statusIn(statusIn), .cfgOut(cfgOut), .sdo(sdo)
  );
endmodule

// File: tb/sim_spiCtrlPort.sv
module sim_spiCtrlPort;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NREG = 8;

  logic clk = 0, rstN = 0, csN = 1, sclk = 0, sdi = 0;
  logic [63:0] statusIn = '0;
  logic [71:0] cfgOut;
  logic sdo;
  int nChecks = 0, nFail = 0;
  logic [8:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  spiCtrlPort u0 (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
                  .statusIn(statusIn), .cfgOut(cfgOut), .sdo(sdo));

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] flatModel();
    logic [71:0] f;
    for (int r = 0; r < NREG; r++) f[r*9 +: 9] = model[r];
    return f;
  endfunction

  function automatic logic [7:0] expRead();
    logic [8:0] c;
    c = model[7];
    if (c[0] && c[1]) return statusIn[c[4:2]*8 +: 8];
    return 8'h00;
  endfunction

  task automatic sendFrame(input logic [31:0] frame, input int n, input bit scramble,
                           output logic [7:0] got, output bit idleOk);
    got = '0; idleOk = 1;
    @(negedge clk) csN = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = frame[n-1-i];
      sclk = 0;
      repeat (HALF) @(negedge clk);
      sclk = 1;
      repeat (HALF-1) @(negedge clk);
      if (i >= 8 && i < 16) got = {got[6:0], sdo};
      else if (sdo !== 1'b0) idleOk = 0;
      if (scramble && i == 8) statusIn = {$urandom, $urandom};
      @(negedge clk);
    end
    sclk = 0;
    repeat (HALF) @(negedge clk);
    csN = 1;
    repeat (6) @(negedge clk);
    if (sdo !== 1'b0) idleOk = 0;
  endtask

  task automatic doFrame(input logic [6:0] addr, input logic [8:0] data, input int n,
                         input bit scramble, input string tag);
    logic [7:0] exp, got;
    logic [31:0] fr;
    bit idleOk;
    exp = expRead();
    fr = {16'h0, addr, data};
    if (n == 15) fr = {17'h0, addr, data[8:1]};
    if (n == 17) fr = {15'h0, addr, data, 1'b1};
    sendFrame(fr, n, scramble, got, idleOk);
    if (n == 16) check({tag, " readback"}, {64'h0, got}, {64'h0, exp});
    check("R8 sdo idle", {71'h0, idleOk}, 72'h1);
    if (n == 16 && addr < 7'(NREG)) model[addr] = data;
    check({tag, " bank"}, cfgOut, flatModel());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int r = 0; r < NREG; r++) model[r] = '0;
    statusIn = 64'hF00D_5A3C_96E1_24B7;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    check("R1 reset bank", cfgOut, 72'h0);
    check("R1 reset sdo", {71'h0, sdo}, 72'h0);

    doFrame(7'd3, 9'h1A5, 16, 0, "R2");
    doFrame(7'd0, 9'h0FF, 16, 0, "R2");
    doFrame(7'd2, 9'h155, 15, 0, "R3 short");
    doFrame(7'd2, 9'h0AA, 17, 0, "R3 long");
    doFrame(7'h45, 9'h1FF, 16, 0, "R4 dummy");
    doFrame(7'd7, 9'h001, 16, 0, "R5");
    doFrame(7'd1, 9'h011, 16, 0, "R5 enable only");
    doFrame(7'd7, 9'h002, 16, 0, "R5");
    doFrame(7'd1, 9'h022, 16, 0, "R5 method only");
    doFrame(7'd7, 9'h017, 16, 0, "R6");       // select byte 5
    doFrame(7'h50, 9'h000, 16, 0, "R6 sel5");
    doFrame(7'd7, 9'h00B, 16, 0, "R7 old sel"); // select byte 2 later
    doFrame(7'd4, 9'h133, 16, 0, "R7 new sel");
    doFrame(7'd5, 9'h0C3, 16, 1, "R9 capture");
    doFrame(7'd6, 9'h03C, 16, 0, "R9 next");

    for (int k = 0; k < 80; k++) begin
      logic [6:0] a;
      logic [8:0] d;
      int n, pick;
      statusIn = {$urandom, $urandom};
      a = 7'($urandom % 12);
      d = 9'($urandom);
      if (a == 7'd7 && ($urandom % 4) != 0) d[1:0] = 2'b11;
      pick = int'($urandom % 10);
      n = (pick == 0) ? 15 : (pick == 1) ? 17 : 16;
      doFrame(a, d, n, ($urandom % 8) == 0, "R6 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule